// File: doc/BRIEF.md
# Prescaled Match-Capture Timer

A timer/counter peripheral with a single-cycle register port. A prescaler divides a count source, either every clock or selected edges of one external input, and each wrap of the prescaler advances the main counter by one. Four compare channels watch the main counter. When the counter reaches a channel's compare value, that channel can raise an interrupt flag, make the next advance load zero, or stop both counters. Each compare value can be refreshed from its own shadow register whenever the counter is forced back to zero. This lets software change the period without a glitch.

Four capture channels pass external inputs through a two-flop synchronizer and an edge detector. On a selected edge they latch the main counter, and they can flag an interrupt. A per-channel waveform mode drives each compare output from a compare of the counter against the channel's compare value.

All registers are 32 bits wide at 4-byte spacing. A write takes effect at the clock edge that samples it. Reads return data in the same cycle.

Top module: `mct_timer`

## Requirements
- R1: With CTRL (0x00) bit 0 set and bit 1 clear, in clock mode, the main counter COUNT (0x10) advances by one every PLIM+1 clock cycles, where PLIM is at 0x08.
- R2: The prescale counter PCNT (0x0C) steps by one per count-source tick until it equals PLIM. It then clears to zero on the next tick, and COUNT advances on that same tick. PCNT, PLIM and COUNT are readable and writable.
- R3: CTRL bit 1 forces COUNT and PCNT to zero and holds them there, whatever bit 0 is. Clearing CTRL bit 0 freezes both counters.
- R4: MACT (0x18) holds three action bits for channel i: bit 3i enables the interrupt, bit 3i+1 enables reset, bit 3i+2 enables stop. When COUNT equals MATCHi (0x40+4i) and reset is enabled, the next advance loads zero, so COUNT cycles through 0..MATCHi.
- R5: When an advance makes COUNT equal MATCHi and stop is enabled, hardware clears CTRL bit 0. COUNT then rests at MATCHi and PCNT rests at 0.
- R6: With SHEN (0x24) bit i set, MATCHi is loaded from SHADOWi (0x50+4i) on every cycle in which COUNT is forced to zero, either by a compare reset or by CTRL bit 1. With the bit clear, MATCHi is left unchanged.
- R7: CCTL (0x1C) holds three bits for channel i: bit 3i captures on a rising edge, bit 3i+1 on a falling edge, bit 3i+2 enables the interrupt. On an enabled edge of cap_in[i], measured after the synchronizer, CAPi (0x60+4i) loads COUNT. An edge that is not enabled leaves CAPi unchanged.
- R8: FLAGS (0x04) holds compare flags in bits 3:0 and capture flags in bits 7:4. An advance that makes COUNT equal MATCHi sets flag i when the interrupt bit is enabled, and an enabled capture sets flag 4+i the same way. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a new event in the same cycle wins over the clear. irq is high while any flag is set.
- R9: CMODE (0x14) bits 1:0 select the count source: 0 every clock, 1 rising edges, 2 falling edges, 3 both edges. Bits 3:2 select the input. Each selected edge of that input is one prescaler tick while counting is enabled, and edges on other inputs are ignored.
- R10: With PWMEN (0x20) bit i set, match_out[i] is low while COUNT < MATCHi and high while COUNT >= MATCHi. It is always high when MATCHi is 0. With the bit clear, match_out[i] is low.
- R11: Writes to CAPi are ignored, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| cap_in | input | 4 | Asynchronous capture / count inputs |
| match_out | output | 4 | Waveform outputs per compare channel |
| irq | output | 1 | OR of all pending flags |

## Verification
Random prescale limits and run lengths, with compare reset on and off, separate a missing or extra prescaler cycle from a wrong wrap point of the reset-on-compare period. Compare-stop runs tell a counter that stops at the compare value apart from one that overshoots by one advance. Capture sequences alternate enabled and disabled edge polarities on random channels with frozen counter values, so a polarity mix-up or a wrong channel shows up as a stale or wrong latched value. Counter-mode pulse trains on the selected input, with decoy pulses on a neighbouring input, separate rising, falling and double-edge counting from input-selection faults. Random counter and compare pairs around equality, including a compare value of zero, probe the waveform outputs.

// File: rtl/mct_pkg.sv
// Shared constants and types for the prescaled match-capture timer.
// Assumes at most four channels, with per-channel registers at 4-byte spacing.
package mct_pkg;
    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_FLAGS  = 8'h04;
    localparam logic [7:0] A_PLIM   = 8'h08;
    localparam logic [7:0] A_PCNT   = 8'h0C;
    localparam logic [7:0] A_COUNT  = 8'h10;
    localparam logic [7:0] A_CMODE  = 8'h14;
    localparam logic [7:0] A_MACT   = 8'h18;
    localparam logic [7:0] A_CCTL   = 8'h1C;
    localparam logic [7:0] A_PWMEN  = 8'h20;
    localparam logic [7:0] A_SHEN   = 8'h24;
    localparam logic [7:0] A_MATCH  = 8'h40;
    localparam logic [7:0] A_SHADOW = 8'h50;
    localparam logic [7:0] A_CAP    = 8'h60;

    // bit positions inside a 3-bit per-channel group
    localparam int GRP_W    = 3;
    localparam int ACT_IRQ  = 0;
    localparam int ACT_RST  = 1;
    localparam int ACT_STOP = 2;
    localparam int CC_RISE  = 0;
    localparam int CC_FALL  = 1;
    localparam int CC_IRQ   = 2;

    typedef enum logic [1:0] {
        SRC_CLOCK = 2'd0,
        SRC_RISE  = 2'd1,
        SRC_FALL  = 2'd2,
        SRC_BOTH  = 2'd3
    } src_mode_e;

    // byte address of channel idx in a per-channel register bank
    function automatic logic [7:0] chan_addr(input logic [7:0] base, input int idx);
        return base + 8'(4 * idx);
    endfunction
endpackage

// File: rtl/mct_edge.sv
// Two-flop synchronizer followed by an edge detector for one asynchronous input.
// Assumes the input stays stable for more than two clock cycles between changes.
module mct_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    // synchronize the input and keep the previous synchronized value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign rise = s2_q & ~prev_q;
    assign fall = ~s2_q & prev_q;

    // R7: a detected edge reflects the input value seen two edges earlier
    a_r7_rise_tracks_input: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(din, 2));
    a_r7_fall_tracks_input: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !$past(din, 2));
endmodule

// File: rtl/mct_count.sv
// Prescaler and main counter. tick is one count-source event. Each wrap of the
// prescaler advances the main counter, or loads zero when rst_req is set.
// Assumes the caller already gates tick with the run and hold controls.
module mct_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold,
    input  logic          rst_req,
    input  logic          wr_count,
    input  logic          wr_pcnt,
    input  logic          wr_plim,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] count,
    output logic [CW-1:0] pcnt,
    output logic [CW-1:0] plim,
    output logic [CW-1:0] nxt,
    output logic          adv,
    output logic          zero_load
);
    logic wrap;

    assign wrap      = (pcnt == plim);
    assign adv       = tick & ~hold & wrap;
    assign nxt       = rst_req ? '0 : count + CW'(1);
    assign zero_load = hold | (adv & rst_req);

    // prescale limit register
    always_ff @(posedge clk) begin
        if (!rst_n)       plim <= '0;
        else if (wr_plim) plim <= wdata;
    end

    // prescale counter: hold, then bus write, then tick
    always_ff @(posedge clk) begin
        if (!rst_n || hold) pcnt <= '0;
        else if (wr_pcnt)   pcnt <= wdata;
        else if (tick)      pcnt <= wrap ? '0 : pcnt + CW'(1);
    end

    // main counter: hold, then bus write, then advance
    always_ff @(posedge clk) begin
        if (!rst_n || hold) count <= '0;
        else if (wr_count)  count <= wdata;
        else if (adv)       count <= nxt;
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rst_req && !wr_count) |=> count == $past(count) + CW'(1));
    a_r2_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_pcnt) |=> pcnt == '0);
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count == '0 && pcnt == '0));
    a_r4_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && rst_req && !wr_count) |=> count == '0);
endmodule

// File: rtl/mct_match.sv
// One compare channel: compare value, its shadow, equality detection and the
// waveform output. Assumes zero_load marks every cycle that forces the counter to zero.
module mct_match #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_match,
    input  logic          wr_shadow,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] nxt,
    input  logic          adv,
    input  logic          zero_load,
    input  logic          shadow_en,
    input  logic          pwm_en,
    output logic [CW-1:0] match_q,
    output logic [CW-1:0] shadow_q,
    output logic          hit,
    output logic          ev,
    output logic          pwm
);
    assign hit = (count == match_q);
    assign ev  = adv & (nxt == match_q);
    assign pwm = pwm_en & ((match_q == '0) | (count >= match_q));

    // compare value: a bus write wins over a shadow reload
    always_ff @(posedge clk) begin
        if (!rst_n)                        match_q <= '0;
        else if (wr_match)                 match_q <= wdata;
        else if (zero_load && shadow_en)   match_q <= shadow_q;
    end

    // shadow value, written only by the bus
    always_ff @(posedge clk) begin
        if (!rst_n)         shadow_q <= '0;
        else if (wr_shadow) shadow_q <= wdata;
    end

    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_load && shadow_en && !wr_match) |=> match_q == $past(shadow_q));
endmodule

// File: rtl/mct_timer.sv
// Top of the prescaled match-capture timer: register file, count-source
// selection, capture channels, interrupt flags and channel instances.
// Assumes NCH <= 4 and CW >= 3*NCH so that every control group fits in one word.
module mct_timer #(
    parameter int CW  = 32,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [7:0]     bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] match_out,
    output logic           irq
);
    import mct_pkg::*;

    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int FW   = 2 * NCH;
    localparam int GW   = GRP_W * NCH;

    logic            wr_en;
    logic            run_q, hold_q;
    logic [FW-1:0]   flags_q, flag_set, flag_clr;
    logic [GW-1:0]   mact_q, cctl_q;
    src_mode_e       mode_q;
    logic [SELW-1:0] csel_q;
    logic [NCH-1:0]  pwmen_q, shen_q;
    logic [CW-1:0]   cap_q [NCH];

    logic [NCH-1:0]  rise, fall, hit, ev, cap_ev;
    logic [NCH-1:0]  act_irq, act_rst, act_stop, cap_irq;
    logic [NCH-1:0]  wr_match, wr_shadow;
    logic [CW-1:0]   match_v [NCH];
    logic [CW-1:0]   shadow_v [NCH];
    logic            src_tick, tick, rst_req, stop_hit;
    logic [CW-1:0]   count, pcnt, plim, nxt;
    logic            adv, zero_load;

    assign wr_en = bus_sel & bus_we;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chan
            mct_edge u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (cap_in[gi]),
                .rise (rise[gi]),
                .fall (fall[gi])
            );

            assign act_irq[gi]   = mact_q[GRP_W*gi + ACT_IRQ];
            assign act_rst[gi]   = mact_q[GRP_W*gi + ACT_RST];
            assign act_stop[gi]  = mact_q[GRP_W*gi + ACT_STOP];
            assign cap_irq[gi]   = cctl_q[GRP_W*gi + CC_IRQ];
            assign cap_ev[gi]    = (rise[gi] & cctl_q[GRP_W*gi + CC_RISE])
                                 | (fall[gi] & cctl_q[GRP_W*gi + CC_FALL]);
            assign wr_match[gi]  = wr_en && (bus_addr == chan_addr(A_MATCH, gi));
            assign wr_shadow[gi] = wr_en && (bus_addr == chan_addr(A_SHADOW, gi));

            mct_match #(.CW(CW)) u_match (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_match (wr_match[gi]),
                .wr_shadow(wr_shadow[gi]),
                .wdata    (bus_wdata),
                .count    (count),
                .nxt      (nxt),
                .adv      (adv),
                .zero_load(zero_load),
                .shadow_en(shen_q[gi]),
                .pwm_en   (pwmen_q[gi]),
                .match_q  (match_v[gi]),
                .shadow_q (shadow_v[gi]),
                .hit      (hit[gi]),
                .ev       (ev[gi]),
                .pwm      (match_out[gi])
            );
        end
    endgenerate

    // pick the count source: every clock or edges of the selected input
    always_comb begin
        case (mode_q)
            SRC_CLOCK: src_tick = 1'b1;
            SRC_RISE:  src_tick = rise[csel_q];
            SRC_FALL:  src_tick = fall[csel_q];
            SRC_BOTH:  src_tick = rise[csel_q] | fall[csel_q];
            default:   src_tick = 1'b0;
        endcase
    end

    assign tick     = src_tick & run_q & ~hold_q;
    assign rst_req  = |(hit & act_rst);
    assign stop_hit = |(ev & act_stop);

    mct_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold     (hold_q),
        .rst_req  (rst_req),
        .wr_count (wr_en && bus_addr == A_COUNT),
        .wr_pcnt  (wr_en && bus_addr == A_PCNT),
        .wr_plim  (wr_en && bus_addr == A_PLIM),
        .wdata    (bus_wdata),
        .count    (count),
        .pcnt     (pcnt),
        .plim     (plim),
        .nxt      (nxt),
        .adv      (adv),
        .zero_load(zero_load)
    );

    // run and hold controls; a compare stop wins over a bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (wr_en && bus_addr == A_CTRL) begin
                run_q  <= bus_wdata[0];
                hold_q <= bus_wdata[1];
            end
            if (stop_hit) run_q <= 1'b0;
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mact_q  <= '0;
            cctl_q  <= '0;
            mode_q  <= SRC_CLOCK;
            csel_q  <= '0;
            pwmen_q <= '0;
            shen_q  <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_MACT:  mact_q  <= bus_wdata[GW-1:0];
                A_CCTL:  cctl_q  <= bus_wdata[GW-1:0];
                A_CMODE: begin
                    mode_q <= src_mode_e'(bus_wdata[1:0]);
                    csel_q <= bus_wdata[2 +: SELW];
                end
                A_PWMEN: pwmen_q <= bus_wdata[NCH-1:0];
                A_SHEN:  shen_q  <= bus_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    // capture registers latch the counter on enabled edges
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n)         cap_q[i] <= '0;
            else if (cap_ev[i]) cap_q[i] <= count;
        end
    end

    assign flag_set = {cap_ev & cap_irq, ev & act_irq};
    assign flag_clr = (wr_en && bus_addr == A_FLAGS) ? bus_wdata[FW-1:0] : '0;

    // pending flags: write-one-to-clear, a new event wins
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign irq = |flags_q;

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = CW'({hold_q, run_q});
                A_FLAGS: bus_rdata = CW'(flags_q);
                A_PLIM:  bus_rdata = plim;
                A_PCNT:  bus_rdata = pcnt;
                A_COUNT: bus_rdata = count;
                A_CMODE: bus_rdata = CW'({csel_q, mode_q});
                A_MACT:  bus_rdata = CW'(mact_q);
                A_CCTL:  bus_rdata = CW'(cctl_q);
                A_PWMEN: bus_rdata = CW'(pwmen_q);
                A_SHEN:  bus_rdata = CW'(shen_q);
                default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == chan_addr(A_MATCH, i))  bus_rdata = match_v[i];
                if (bus_addr == chan_addr(A_SHADOW, i)) bus_rdata = shadow_v[i];
                if (bus_addr == chan_addr(A_CAP, i))    bus_rdata = cap_q[i];
            end
        end
    end

    a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !run_q);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags_q) & ~$past(flag_clr) & ~flags_q) == '0));
endmodule

// File: tb/mct_timer_tb.sv
`timescale 1ns/1ps
module mct_timer_tb;
    import mct_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  cap_in = '0, match_out;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    mct_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .match_out(match_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int ch);
        @(negedge clk); cap_in[ch] = 1'b1;
        repeat (3) @(negedge clk);
        cap_in[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // clear counters, then run for exactly t ticks in clock mode
    task automatic run_ticks(input int t);
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h1);
        repeat (t - 1) @(posedge clk);
        wr(A_CTRL, 32'h0);
    endtask

    function automatic logic exp_pwm(input int m, input int v);
        return (m == 0) || (v >= m);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v, v2;
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd(A_COUNT, d); check("R1", "reset count", d, 0);
        rd(A_FLAGS, d); check("R8", "reset flags", d, 0);
        rd(A_CTRL, d);  check("R3", "reset ctrl", d, 0);
        check("R8", "reset irq", {31'd0, irq}, 0);
        check("R10", "reset match_out", {28'd0, match_out}, 0);

        // R1 / R2: random prescale limits and run lengths, no compare action
        wr(A_MACT, 0);
        for (int it = 0; it < 8; it++) begin
            int p, t;
            p = $urandom_range(0, 5); t = $urandom_range(1, 40);
            wr(A_PLIM, p);
            run_ticks(t);
            rd(A_COUNT, d); check("R1", "count after ticks", d, t / (p + 1));
            rd(A_PCNT, d);  check("R2", "pcnt after ticks", d, t % (p + 1));
        end

        // R2: bus-written counters continue from the written values
        wr(A_CTRL, 32'h0);
        wr(A_PLIM, 5); wr(A_PCNT, 3); wr(A_COUNT, 100);
        wr(A_CTRL, 1); repeat (2) @(posedge clk); wr(A_CTRL, 0);
        rd(A_PCNT, d);  check("R2", "written pcnt wraps", d, 0);
        rd(A_COUNT, d); check("R2", "written count advances", d, 101);

        // R3: hold forces zero even with run set
        wr(A_CTRL, 32'h3); repeat (5) @(posedge clk);
        rd(A_COUNT, d); check("R3", "hold count", d, 0);
        rd(A_PCNT, d);  check("R3", "hold pcnt", d, 0);
        wr(A_CTRL, 0);

        // R4 / R8: reset-on-compare period and interrupt flag
        for (int it = 0; it < 8; it++) begin
            int p, m, t, a;
            p = $urandom_range(0, 3); m = $urandom_range(1, 9); t = $urandom_range(1, 60);
            a = t / (p + 1);
            wr(A_CTRL, 2); wr(A_FLAGS, 32'hFF);
            wr(A_PLIM, p); wr(A_MATCH, m); wr(A_MACT, 32'h3);
            run_ticks(t);
            rd(A_COUNT, d); check("R4", "count with compare reset", d, a % (m + 1));
            rd(A_PCNT, d);  check("R2", "pcnt with compare reset", d, t % (p + 1));
            rd(A_FLAGS, d); check("R8", "compare flag 0", d & 1, (a >= m) ? 1 : 0);
        end

        // R5: stop on channel 1 (stop bit 5, irq bit 3)
        for (int it = 0; it < 4; it++) begin
            int p, m;
            p = $urandom_range(0, 3); m = $urandom_range(1, 8);
            wr(A_CTRL, 2); wr(A_FLAGS, 32'hFF);
            wr(A_PLIM, p); wr(chan_addr(A_MATCH, 1), m); wr(A_MACT, 32'h28);
            wr(A_CTRL, 1);
            repeat ((m + 2) * (p + 1) + 5) @(posedge clk);
            rd(A_CTRL, d);  check("R5", "run cleared by stop", d, 0);
            rd(A_COUNT, d); check("R5", "count rests at compare", d, m);
            rd(A_PCNT, d);  check("R5", "pcnt rests at zero", d, 0);
            rd(A_FLAGS, d); check("R8", "compare flag 1", d & 2, 2);
            check("R8", "irq with flag", {31'd0, irq}, 1);
        end
        wr(A_FLAGS, 0);
        rd(A_FLAGS, d); check("R8", "write 0 keeps flag", d & 2, 2);
        wr(A_FLAGS, 2);
        rd(A_FLAGS, d); check("R8", "write 1 clears flag", d, 0);
        check("R8", "irq cleared", {31'd0, irq}, 0);

        // R6: shadow reload on compare reset, with and without enable
        for (int it = 0; it < 4; it++) begin
            int m, s, e, en;
            m = $urandom_range(1, 5); s = $urandom_range(6, 12); e = $urandom_range(0, 3);
            en = it % 2;
            wr(A_CTRL, 2); wr(A_CTRL, 0); wr(A_SHEN, 0);
            wr(A_PLIM, 0); wr(A_MATCH, m); wr(A_SHADOW, s); wr(A_MACT, 32'h2);
            wr(A_SHEN, en);
            wr(A_CTRL, 1); repeat (m + e) @(posedge clk); wr(A_CTRL, 0);
            rd(A_MATCH, d); check("R6", "compare after reset", d, en ? s : m);
            rd(A_COUNT, d); check("R4", "count after period", d, en ? e : (m + 1 + e) % (m + 1));
        end
        wr(A_SHADOW, 77); wr(A_SHEN, 1); wr(A_CTRL, 2); wr(A_CTRL, 0);
        rd(A_MATCH, d); check("R6", "reload on hold", d, 77);
        wr(A_SHEN, 0); wr(A_MACT, 0);

        // R7 / R8: captures on random channels and polarities
        for (int it = 0; it < 6; it++) begin
            int ch;
            ch = $urandom_range(0, 3);
            v = $urandom; v2 = $urandom;
            wr(A_FLAGS, 32'hFF);
            wr(A_COUNT, v); wr(A_CCTL, 32'h5 << (3 * ch));
            @(negedge clk); cap_in[ch] = 1'b1; repeat (4) @(posedge clk);
            rd(chan_addr(A_CAP, ch), d); check("R7", "rising capture", d, v);
            rd(A_FLAGS, d); check("R8", "capture flag", d, 32'h10 << ch);
            wr(A_COUNT, v2); wr(A_CCTL, 32'h1 << (3 * ch));
            @(negedge clk); cap_in[ch] = 1'b0; repeat (4) @(posedge clk);
            rd(chan_addr(A_CAP, ch), d); check("R7", "disabled falling edge ignored", d, v);
            wr(A_CCTL, 32'h2 << (3 * ch));
            @(negedge clk); cap_in[ch] = 1'b1; repeat (4) @(posedge clk);
            rd(chan_addr(A_CAP, ch), d); check("R7", "disabled rising edge ignored", d, v);
            @(negedge clk); cap_in[ch] = 1'b0; repeat (4) @(posedge clk);
            rd(chan_addr(A_CAP, ch), d); check("R7", "falling capture", d, v2);
            // R11: capture registers ignore writes
            wr(chan_addr(A_CAP, ch), ~v2);
            rd(chan_addr(A_CAP, ch), d); check("R11", "capture write ignored", d, v2);
        end
        wr(A_CCTL, 0); wr(A_FLAGS, 32'hFF);
        rd(8'hFC, d); check("R11", "unmapped read", d, 0);

        // R9: counter mode with decoy pulses on another input
        for (int it = 0; it < 6; it++) begin
            int mode, sel, k, other;
            mode = $urandom_range(1, 3); sel = $urandom_range(0, 3); k = $urandom_range(1, 5);
            other = (sel + 1) % 4;
            wr(A_CTRL, 2); wr(A_CTRL, 0); wr(A_PLIM, 0);
            wr(A_CMODE, mode | (sel << 2)); wr(A_CTRL, 1);
            for (int j = 0; j < k; j++) pulse(sel);
            pulse(other); pulse(other);
            repeat (5) @(posedge clk);
            rd(A_COUNT, d); check("R9", "counted edges", d, (mode == 3) ? 2 * k : k);
            wr(A_CTRL, 0); wr(A_CMODE, 0);
        end

        // R10: waveform output against compare value
        for (int it = 0; it < 10; it++) begin
            int m, v3;
            m = (it == 0) ? 0 : $urandom_range(0, 20);
            v3 = (it == 1) ? m : $urandom_range(0, 20);
            wr(chan_addr(A_MATCH, 2), m); wr(A_PWMEN, 32'h4); wr(A_COUNT, v3);
            @(negedge clk);
            check("R10", "pwm output", {31'd0, match_out[2]}, {31'd0, exp_pwm(m, v3)});
            wr(A_PWMEN, 0); @(negedge clk);
            check("R10", "pwm disabled low", {28'd0, match_out}, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule